// File: doc/BRIEF.md
# ADC Result Code Formatter

This block sits between a converter model and the rest of a data path. Each accepted sample is a signed fixed-point difference, scaled so that the reference voltage VREF equals 2^VREF_LOG2 counts. The block turns that sample into a CODE_W-bit result code. Two mode bits arrive with the sample. The input-type bit selects single-ended mode, where the sample is the chosen input measured against ground, or pseudo-differential mode, where it is the positive input minus the negative input. The polarity bit selects straight binary output over 0..VREF or two's complement output over ±VREF/2.

Single-ended mode always uses the unipolar mapping, whatever the polarity bit says. A negative value in unipolar mode gives code zero and does not wrap. Values outside the range saturate at the end codes. The code, a flag naming the encoding that was used, and a valid strobe are registered, so they appear one clock after the sample is accepted. One code LSB equals 2^(VREF_LOG2-CODE_W) input counts. Scaling truncates toward minus infinity.

Top module: `adc_code_fmt`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0, out_code is 0x00 and out_bip is 0, which means unipolar.
- R2: out_valid equals in_valid delayed by exactly one clock. The code and out_bip that go with a sample update on that same edge, from mode bits taken in the same cycle as the sample.
- R3: While in_valid is 0, out_code and out_bip keep their previous values.
- R4: When in_single is 1, the unipolar mapping is used and out_bip is 0, even if in_bip is 1.
- R5: In unipolar mode (in_single=1, or in_single=0 with in_bip=0), a sample x with 0 <= x < 2^VREF_LOG2 gives the straight-binary code floor(x / 2^(VREF_LOG2-CODE_W)). With the defaults that is x/4 for x in 0..1023.
- R6: In unipolar mode, any negative sample gives code 0x00.
- R7: In unipolar mode, a sample at or above 2^VREF_LOG2 gives the all-ones code, 0xFF with the defaults.
- R8: In bipolar mode (in_single=0, in_bip=1), a sample x with -2^(VREF_LOG2-1) <= x < 2^(VREF_LOG2-1) gives the two's-complement code floor(x / 2^(VREF_LOG2-CODE_W)). With the defaults, -512 gives 0x80 and -5 gives 0xFE.
- R9: In bipolar mode, a sample at or above +2^(VREF_LOG2-1) gives 0x7F, and a sample below -2^(VREF_LOG2-1) gives 0x80.
- R10: out_bip is 1 exactly when the registered code was produced by the bipolar mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample and mode bits are valid this cycle |
| in_sample | input | IN_W | Signed sample; VREF = 2^VREF_LOG2 counts |
| in_single | input | 1 | 1 = single-ended, 0 = pseudo-differential |
| in_bip | input | 1 | 1 = bipolar, 0 = unipolar (pseudo-differential only) |
| out_valid | output | 1 | Registered result strobe |
| out_code | output | CODE_W | Result code |
| out_bip | output | 1 | Encoding of out_code: 1 = two's complement |

## Verification
The assertions assume that in_sample and both mode bits have a known value in every cycle in which in_valid is high, and that a sample with its modes is only counted as accepted on such a cycle. The bench sets sample and modes on the falling edge, together with in_valid. When in_valid is low it still drives the sample and mode inputs to deliberately different, fully defined values, so the hold checks see inputs that could disturb the outputs but never undefined ones. Every sample the bench applies fits in IN_W bits, including the most negative and most positive values, which lie outside the analog range.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;

   // Encoding that the output stage reports alongside each code
   typedef enum logic {
      ENC_STRAIGHT = 1'b0,
      ENC_TWOS     = 1'b1
   } enc_e;

   // Effective encoding after the single-ended override
   function automatic enc_e pick_enc(input logic single, input logic bip);
      return (bip && !single) ? ENC_TWOS : ENC_STRAIGHT;
   endfunction

endpackage

// File: rtl/adcfmt_uni_map.sv
module adcfmt_uni_map #(
   parameter int IN_W      = 12,
   parameter int CODE_W    = 8,
   parameter int VREF_LOG2 = 10
) (
   input  logic signed [IN_W-1:0] sample_i,
   output logic [CODE_W-1:0]      code_o
);
   localparam int SHIFT = VREF_LOG2 - CODE_W;
   localparam logic signed [IN_W-1:0] FULL = {{(IN_W-1){1'b0}}, 1'b1} << VREF_LOG2;

   logic [CODE_W-1:0] scaled;

   generate
      if (SHIFT == 0) begin : g_direct
         assign scaled = CODE_W'(sample_i);
      end else begin : g_shifted
         assign scaled = CODE_W'(sample_i >>> SHIFT);
      end
   endgenerate

   always_comb begin
      if (sample_i[IN_W-1])
         code_o = '0;
      else if (sample_i >= FULL)
         code_o = '1;
      else
         code_o = scaled;
   end
endmodule

// File: rtl/adcfmt_bip_map.sv
module adcfmt_bip_map #(
   parameter int IN_W      = 12,
   parameter int CODE_W    = 8,
   parameter int VREF_LOG2 = 10
) (
   input  logic signed [IN_W-1:0] sample_i,
   output logic [CODE_W-1:0]      code_o
);
   localparam int SHIFT = VREF_LOG2 - CODE_W;
   localparam logic signed [IN_W-1:0] HALF     = {{(IN_W-1){1'b0}}, 1'b1} << (VREF_LOG2 - 1);
   localparam logic signed [IN_W-1:0] NEG_HALF = -HALF;
   localparam logic [CODE_W-1:0] CODE_MAX = {1'b0, {(CODE_W-1){1'b1}}};
   localparam logic [CODE_W-1:0] CODE_MIN = {1'b1, {(CODE_W-1){1'b0}}};

   logic [CODE_W-1:0] scaled;

   generate
      if (SHIFT == 0) begin : g_direct
         assign scaled = CODE_W'(sample_i);
      end else begin : g_shifted
         assign scaled = CODE_W'(sample_i >>> SHIFT);
      end
   endgenerate

   always_comb begin
      if (sample_i >= HALF)
         code_o = CODE_MAX;
      else if (sample_i < NEG_HALF)
         code_o = CODE_MIN;
      else
         code_o = scaled;
   end
endmodule

// File: rtl/adcfmt_out_stage.sv
module adcfmt_out_stage #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              enc_i,
   output logic              valid_o,
   output logic [CODE_W-1:0] code_o,
   output logic              enc_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         code_o  <= '0;
         enc_o   <= 1'b0;
      end else begin
         valid_o <= load_i;
         if (load_i) begin
            code_o <= code_i;
            enc_o  <= enc_i;
         end
      end
   end
endmodule

// File: rtl/adc_code_fmt.sv
module adc_code_fmt
   import adcfmt_pkg::*;
#(
   parameter int IN_W      = 12,
   parameter int CODE_W    = 8,
   parameter int VREF_LOG2 = 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic signed [IN_W-1:0] in_sample,
   input  logic                   in_single,
   input  logic                   in_bip,
   output logic                   out_valid,
   output logic [CODE_W-1:0]      out_code,
   output logic                   out_bip
);
   localparam logic signed [IN_W-1:0] FULL     = {{(IN_W-1){1'b0}}, 1'b1} << VREF_LOG2;
   localparam logic signed [IN_W-1:0] HALF     = FULL >>> 1;
   localparam logic signed [IN_W-1:0] NEG_HALF = -HALF;
   localparam logic [CODE_W-1:0] CODE_MAX = {1'b0, {(CODE_W-1){1'b1}}};
   localparam logic [CODE_W-1:0] CODE_MIN = {1'b1, {(CODE_W-1){1'b0}}};

   generate
      if (VREF_LOG2 < CODE_W) begin : g_bad_scale
         $error("adc_code_fmt: VREF_LOG2 must be at least CODE_W");
      end
      if (IN_W < VREF_LOG2 + 2) begin : g_bad_width
         $error("adc_code_fmt: IN_W must exceed VREF_LOG2 by two or more");
      end
      if (CODE_W < 2) begin : g_bad_code
         $error("adc_code_fmt: CODE_W must be at least 2");
      end
   endgenerate

   logic [CODE_W-1:0] uni_code;
   logic [CODE_W-1:0] bip_code;
   logic [CODE_W-1:0] sel_code;
   enc_e              enc;

   adcfmt_uni_map #(.IN_W(IN_W), .CODE_W(CODE_W), .VREF_LOG2(VREF_LOG2)) u_uni (
      .sample_i (in_sample),
      .code_o   (uni_code)
   );

   adcfmt_bip_map #(.IN_W(IN_W), .CODE_W(CODE_W), .VREF_LOG2(VREF_LOG2)) u_bip (
      .sample_i (in_sample),
      .code_o   (bip_code)
   );

   assign enc      = pick_enc(in_single, in_bip);
   assign sel_code = (enc == ENC_TWOS) ? bip_code : uni_code;

   adcfmt_out_stage #(.CODE_W(CODE_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (in_valid),
      .code_i  (sel_code),
      .enc_i   (enc),
      .valid_o (out_valid),
      .code_o  (out_code),
      .enc_o   (out_bip)
   );

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid)) else $error("valid latency"); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_code) && $stable(out_bip))) else $error("hold"); // R3
   AST_SINGLE_UNIPOLAR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_single) |=> !out_bip) else $error("single-ended polarity"); // R4
   AST_UNI_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_single || !in_bip) && in_sample[IN_W-1]) |=> (out_code == '0)) else $error("neg clamp"); // R6
   AST_UNI_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_single || !in_bip) && in_sample >= FULL) |=> (out_code == '1)) else $error("uni sat"); // R7
   AST_BIP_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_single && in_bip && in_sample >= HALF) |=> (out_code == CODE_MAX)) else $error("bip hi"); // R9
   AST_BIP_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_single && in_bip && in_sample < NEG_HALF) |=> (out_code == CODE_MIN)) else $error("bip lo"); // R9
   AST_ENC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_bip == $past(in_bip && !in_single))) else $error("enc flag"); // R10
endmodule

// File: tb/adc_code_fmt_tb.sv
module adc_code_fmt_tb_top;
   localparam int IN_W = 12;
   localparam int CODE_W = 8;
   localparam int VREF_LOG2 = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [IN_W-1:0] in_sample = '0;
   logic in_single = 1'b0;
   logic in_bip = 1'b0;
   logic out_valid;
   logic [CODE_W-1:0] out_code;
   logic out_bip;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10ns clk = ~clk;

   adc_code_fmt #(.IN_W(IN_W), .CODE_W(CODE_W), .VREF_LOG2(VREF_LOG2)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .in_single(in_single), .in_bip(in_bip),
      .out_valid(out_valid), .out_code(out_code), .out_bip(out_bip)
   );

   // Reference mapping: VREF = 1024 counts, LSB = 4 counts
   function automatic int ref_code(int x, bit se, bit bip);
      if (bip && !se) begin
         if (x >= 512) return 8'h7F;
         if (x < -512) return 8'h80;
         return (x >>> 2) & 8'hFF;
      end
      if (x < 0) return 0;
      if (x >= 1024) return 8'hFF;
      return x >>> 2;
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic apply(string req, int x, bit se, bit bip);
      @(negedge clk);
      in_valid = 1'b1; in_sample = IN_W'(x); in_single = se; in_bip = bip;
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " valid"}, int'(out_valid), 1);
      check({req, " code"}, int'(out_code), ref_code(x, se, bip));
      check({req, " enc"}, int'(out_bip), int'(bip && !se));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 valid", int'(out_valid), 0);
      check("R1 code", int'(out_code), 0);
      check("R1 enc", int'(out_bip), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 post valid", int'(out_valid), 0);
      check("R1 post code", int'(out_code), 0);
   endtask

   task automatic t_unipolar();
      foreach (uni_pts[i]) apply("R5", uni_pts[i], 1'b0, 1'b0);
      apply("R6", -1, 1'b0, 1'b0);
      apply("R6", -2048, 1'b0, 1'b0);
      apply("R7", 1024, 1'b0, 1'b0);
      apply("R7", 2047, 1'b0, 1'b0);
   endtask

   task automatic t_single();
      foreach (uni_pts[i]) apply("R4", uni_pts[i], 1'b1, 1'b1);
      apply("R4 neg", -700, 1'b1, 1'b1);
      apply("R4 top", 1500, 1'b1, 1'b1);
      apply("R4 plain", 600, 1'b1, 1'b0);
   endtask

   task automatic t_bipolar();
      foreach (bip_pts[i]) apply("R8", bip_pts[i], 1'b0, 1'b1);
      apply("R9 hi", 512, 1'b0, 1'b1);
      apply("R9 hi", 2047, 1'b0, 1'b1);
      apply("R9 lo", -513, 1'b0, 1'b1);
      apply("R9 lo", -2048, 1'b0, 1'b1);
   endtask

   task automatic t_hold();
      apply("R10", -100, 1'b0, 1'b1);
      @(negedge clk);
      in_valid = 1'b0; in_sample = 12'sd300; in_single = 1'b1; in_bip = 1'b0;
      @(negedge clk);
      check("R2 idle valid", int'(out_valid), 0);
      check("R3 code held", int'(out_code), ref_code(-100, 1'b0, 1'b1));
      check("R3 enc held", int'(out_bip), 1);
      // back-to-back samples with mode change each cycle
      in_valid = 1'b1; in_sample = 12'sd800; in_single = 1'b0; in_bip = 1'b1;
      @(negedge clk);
      check("R2 b2b first", int'(out_code), 8'h7F);
      check("R10 b2b first", int'(out_bip), 1);
      in_sample = 12'sd800; in_bip = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      check("R2 b2b second", int'(out_code), 200);
      check("R10 b2b second", int'(out_bip), 0);
      check("R2 b2b valid", int'(out_valid), 1);
   endtask

   int uni_pts[8] = '{0, 1, 3, 4, 511, 512, 1020, 1023};
   int bip_pts[9] = '{0, 3, 4, -1, -4, -5, 508, 511, -512};

   initial begin
      t_reset();
      t_unipolar();
      t_single();
      t_bipolar();
      t_hold();
      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule